// File: doc/BRIEF.md
# Outer-Product Accumulate Command Sequencer

This block turns one 64-bit operand word for a floating-point outer-product accumulate into a stream of per-element commands. A downstream FMA datapath uses these commands to compute z[j][i] = f(x[i], y[j], z[j][i]). On a start strobe the sequencer decodes the word. It finds the no-op cases, the ALU operation, the lane width and the Z row selector, and it samples the X and Y lane-enable masks supplied by a separate mask generator. It then walks every enabled (Y lane, X lane) pair. The Y lane is the outer loop and the X lane is the inner loop.

One command leaves per accepted cycle on a valid/ready stream. A command names the Z register to update, the X lane, the Y lane, an ALU code and a force-zero flag. Disabled lanes cost no cycles. A single-cycle done pulse closes every operation, including operations that produce no commands.

The sequencer does no arithmetic and holds no register file. Operand offsets, indexed loads and shuffles belong to other blocks.

Top module: `opacc_cmd_seq`

## Requirements
- R1: While reset is held low, and in the first cycle after it, `cmd_valid_o` and `done_o` are 0.
- R2: If any of operand bits 56..54 is nonzero, no command is emitted and `done_o` pulses in the cycle after the start is taken.
- R3: With operand bit 53 clear, the ALU mode is bits 52..47. Mode 0 gives `cmd_alu_o`=0 (z+x*y), mode 1 gives 1 (z-x*y) and mode 4 gives 2 (select: x<=0 ? 0 : y). Every other mode is a no-op that behaves as in R2.
- R4: With operand bit 53 set, the ALU mode is taken as 0 (code 0) whatever bits 52..47 hold.
- R5: Bits 45..42 choose the widths. The value 3 selects 16-bit X/Y with 32-bit Z, 4 selects 32/32, 7 selects 64/64, and any other value selects 16/16. The lane count is 32, 16 or 8 for 16-, 32- or 64-bit elements. Lane k is enabled when mask bit k*bytes is set, where bytes is 2, 4 or 8. Other mask bits have no effect.
- R6: In 16/16 mode the Z register is 2*j with bit 0 replaced by bit 20 of the operand (the Z row field is bits 22..20).
- R7: In 32/32 mode the Z register is 4*j + zrow[1:0]. In 64/64 mode it is 8*j + zrow[2:0].
- R8: In mixed 16-in/32-accumulate mode the Z register is 2*j + (i mod 2), and the Z row field is ignored.
- R9: Commands cover exactly the enabled pairs, in ascending j and then ascending i. With ready held high they come on consecutive cycles, starting the cycle after the start.
- R10: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, every command output holds its value.
- R11: `done_o` is a one-cycle pulse in the cycle after the last command is accepted. If the start found no enabled pair, or found a no-op, it comes in the cycle after the start.
- R12: A start strobe that arrives while commands are still pending is ignored.
- R13: The force-zero flag is set in two cases. Case one: bits 40..38 are 0 and bits 36..32 equal 3. Case two: bits 25..23 are 0 and bits 62..58 equal 3. Bits 37 and 63 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken when idle |
| op_i | input | 64 | Operand word |
| xen_i | input | 64 | X lane-enable byte mask |
| yen_i | input | 64 | Y lane-enable byte mask |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Downstream accepts command |
| cmd_zreg_o | output | 6 | Target Z register index |
| cmd_xlane_o | output | 5 | X lane index i |
| cmd_ylane_o | output | 5 | Y lane index j |
| cmd_alu_o | output | 2 | ALU code: 0 add, 1 subtract, 2 select |
| cmd_fz_o | output | 1 | Force the result to zero |
| done_o | output | 1 | Operation finished pulse |

## Verification
The bench targets these corner cases:
- **Mask bits between lane boundaries.** A design that sampled the mask per byte would emit extra commands.
- **Mixed width mode.** A sequencer that reused the 16/16 row mapping would write only every other Z register and ignore X lane parity.
- **Mode 5 with bit 53 set.** A design that skipped the forcing rule would drop the operation as a no-op.
- **Masks that become empty after sampling, and the no-op encodings.** Both must still return a done pulse, or the issuer would hang.
- **Stalls and starts during a stall.** A stall with a second start in the middle exposes command fields that change under back-pressure, and a sequencer that restarts on the second strobe.
- **Set ignored bits 37 and 63.** With these bits set, a design that read them would lose the force-zero flag.

// File: rtl/opacc_pkg.sv
// Package: shared types for the outer-product command sequencer.
// Assumes: no parameters; the encodings are fixed by the command format.
package opacc_pkg;

    // Lane width configuration decoded from the operand.
    typedef enum logic [1:0] {
        LW_16  = 2'd0,   // 16-bit X/Y, 16-bit Z
        LW_MIX = 2'd1,   // 16-bit X/Y, 32-bit Z, every Z row used
        LW_32  = 2'd2,   // 32-bit everywhere
        LW_64  = 2'd3    // 64-bit everywhere
    } lw_e;

    // ALU code carried in each command.
    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,  // z + x*y
        ALU_SUB = 2'd1,  // z - x*y
        ALU_SEL = 2'd2   // x <= 0 ? 0 : y
    } alu_e;

endpackage

// File: rtl/opacc_decode.sv
// Module: opacc_decode
// Purpose: purely combinational decode of the 64-bit operand into a no-op
//          flag, ALU code, lane width, Z row selector and force-zero flag.
// Assumes: operand layout is fixed; offsets and index-load fields belong to
//          other blocks and are deliberately left unused here.
module opacc_decode
    import opacc_pkg::*;
(
    input  logic [63:0] op_i,
    output logic        noop_o,
    output alu_e        alu_o,
    output lw_e         lw_o,
    output logic [2:0]  zrow_o,
    output logic        fz_o
);

    logic [5:0] mode;
    logic       mode_ok;

    // Select the ALU mode; the indexed-load flag forces mode 0.
    always_comb begin
        mode = op_i[53] ? 6'd0 : op_i[52:47];
    end

    // Map the ALU mode to a command code, flagging unsupported modes.
    always_comb begin
        mode_ok = 1'b1;
        alu_o   = ALU_ADD;
        case (mode)
            6'd0:    alu_o = ALU_ADD;
            6'd1:    alu_o = ALU_SUB;
            6'd4:    alu_o = ALU_SEL;
            default: mode_ok = 1'b0;
        endcase
    end

    // A nonzero reserved field or an unsupported mode cancels the operation.
    always_comb begin
        noop_o = (op_i[56:54] != 3'd0) || !mode_ok;
    end

    // Lane width selection from the width field.
    always_comb begin
        case (op_i[45:42])
            4'd3:    lw_o = LW_MIX;
            4'd4:    lw_o = LW_32;
            4'd7:    lw_o = LW_64;
            default: lw_o = LW_16;
        endcase
    end

    // Z row selector and the zero-override detection (bits 37, 63 excluded).
    always_comb begin
        zrow_o = op_i[22:20];
        fz_o   = ((op_i[40:38] == 3'd0) && (op_i[36:32] == 5'd3)) ||
                 ((op_i[25:23] == 3'd0) && (op_i[62:58] == 5'd3));
    end

    logic unused_op;
    assign unused_op = ^{op_i[63], op_i[57], op_i[46], op_i[41], op_i[37],
                         op_i[31:26], op_i[19:0]};

endmodule

// File: rtl/opacc_lane_mask.sv
// Module: opacc_lane_mask
// Purpose: gathers one enable bit per lane from a byte mask. Lane k reads
//          mask bit k*bytes, where bytes is 2, 4 or 8 by element width.
// Assumes: LANES is a power of two, at least 8, and the mask is 2*LANES bits.
module opacc_lane_mask
    import opacc_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [2*LANES-1:0] mask_i,
    input  lw_e                lw_i,
    output logic [LANES-1:0]   lanes_o
);

    localparam int LANES32 = LANES / 2;
    localparam int LANES64 = LANES / 4;

    logic [LANES-1:0] s16;
    logic [LANES-1:0] s32;
    logic [LANES-1:0] s64;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign s16[k] = mask_i[2*k];
        if (k < LANES32) begin : g_w32
            assign s32[k] = mask_i[4*k];
        end else begin : g_w32_off
            assign s32[k] = 1'b0;
        end
        if (k < LANES64) begin : g_w64
            assign s64[k] = mask_i[8*k];
        end else begin : g_w64_off
            assign s64[k] = 1'b0;
        end
    end

    // Pick the gathered vector matching the element width.
    always_comb begin
        case (lw_i)
            LW_32:   lanes_o = s32;
            LW_64:   lanes_o = s64;
            default: lanes_o = s16;
        endcase
    end

    logic unused_mask;
    assign unused_mask = ^mask_i;

endmodule

// File: rtl/opacc_first_set.sv
// Module: opacc_first_set
// Purpose: finds the lowest set bit of a lane vector and reports its index.
// Assumes: idx_o is 0 when nothing is set; callers must qualify with found_o.
module opacc_first_set #(
    parameter int LANES = 32,
    localparam int LIDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  vec_i,
    output logic              found_o,
    output logic [LIDX_W-1:0] idx_o
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (vec_i[k]) begin
                found_o = 1'b1;
                idx_o   = LIDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/opacc_cmd_seq.sv
// Module: opacc_cmd_seq (top)
// Purpose: on start, decodes the operand and samples both lane masks. It then
//          emits one command per accepted cycle for each enabled (j, i) pair,
//          j outer and i inner, and pulses done after the last acceptance.
// Assumes: masks and operand are valid in the start cycle only; starts are
//          ignored while a command is pending; LANES >= 8, a power of two.
module opacc_cmd_seq
    import opacc_pkg::*;
#(
    parameter int LANES = 32,
    localparam int LIDX_W = $clog2(LANES),
    localparam int ZREG_W = $clog2(2 * LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [63:0]       op_i,
    input  logic [2*LANES-1:0] xen_i,
    input  logic [2*LANES-1:0] yen_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [ZREG_W-1:0] cmd_zreg_o,
    output logic [LIDX_W-1:0] cmd_xlane_o,
    output logic [LIDX_W-1:0] cmd_ylane_o,
    output logic [1:0]        cmd_alu_o,
    output logic              cmd_fz_o,
    output logic              done_o
);

    // Decode of the incoming operand (used only in the start cycle).
    logic       dec_noop;
    alu_e       dec_alu;
    lw_e        dec_lw;
    logic [2:0] dec_zrow;
    logic       dec_fz;

    opacc_decode u_dec (
        .op_i   (op_i),
        .noop_o (dec_noop),
        .alu_o  (dec_alu),
        .lw_o   (dec_lw),
        .zrow_o (dec_zrow),
        .fz_o   (dec_fz)
    );

    logic [LANES-1:0] x_in;
    logic [LANES-1:0] y_in;

    opacc_lane_mask #(.LANES(LANES)) u_xmask (
        .mask_i (xen_i), .lw_i (dec_lw), .lanes_o (x_in)
    );
    opacc_lane_mask #(.LANES(LANES)) u_ymask (
        .mask_i (yen_i), .lw_i (dec_lw), .lanes_o (y_in)
    );

    // Latched operation state.
    logic [LANES-1:0]  x_vec;
    logic [LANES-1:0]  y_vec;
    lw_e               lw_q;
    alu_e              alu_q;
    logic [2:0]        zrow_q;
    logic              fz_q;
    logic [LIDX_W-1:0] cur_i;
    logic [LIDX_W-1:0] cur_j;
    logic              valid_q;
    logic              done_q;

    // Remaining-lane vectors above the current position.
    logic [LANES-1:0] x_above;
    logic [LANES-1:0] y_above;

    // Build masks of lanes strictly above the current indices.
    always_comb begin
        x_above = x_vec & ({LANES{1'b1}} << (32'(cur_i) + 32'd1));
        y_above = y_vec & ({LANES{1'b1}} << (32'(cur_j) + 32'd1));
    end

    logic              fx_in_ok, fy_in_ok, fx0_ok, fxn_ok, fyn_ok;
    logic [LIDX_W-1:0] fx_in, fy_in, fx0, fxn, fyn;

    opacc_first_set #(.LANES(LANES)) u_fx_in (
        .vec_i (x_in),    .found_o (fx_in_ok), .idx_o (fx_in)
    );
    opacc_first_set #(.LANES(LANES)) u_fy_in (
        .vec_i (y_in),    .found_o (fy_in_ok), .idx_o (fy_in)
    );
    opacc_first_set #(.LANES(LANES)) u_fx0 (
        .vec_i (x_vec),   .found_o (fx0_ok),   .idx_o (fx0)
    );
    opacc_first_set #(.LANES(LANES)) u_fxn (
        .vec_i (x_above), .found_o (fxn_ok),   .idx_o (fxn)
    );
    opacc_first_set #(.LANES(LANES)) u_fyn (
        .vec_i (y_above), .found_o (fyn_ok),   .idx_o (fyn)
    );

    // Start capture, lane walk and done generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            x_vec   <= '0;
            y_vec   <= '0;
            lw_q    <= LW_16;
            alu_q   <= ALU_ADD;
            zrow_q  <= '0;
            fz_q    <= 1'b0;
            cur_i   <= '0;
            cur_j   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!valid_q) begin
                if (start_i) begin
                    x_vec  <= x_in;
                    y_vec  <= y_in;
                    lw_q   <= dec_lw;
                    alu_q  <= dec_alu;
                    zrow_q <= dec_zrow;
                    fz_q   <= dec_fz;
                    if (!dec_noop && fx_in_ok && fy_in_ok) begin
                        valid_q <= 1'b1;
                        cur_i   <= fx_in;
                        cur_j   <= fy_in;
                    end else begin
                        done_q <= 1'b1;
                    end
                end
            end else if (cmd_ready_i) begin
                if (fxn_ok) begin
                    cur_i <= fxn;
                end else if (fyn_ok) begin
                    cur_j <= fyn;
                    cur_i <= fx0;
                end else begin
                    valid_q <= 1'b0;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    // Z register mapping per lane width mode.
    always_comb begin
        case (lw_q)
            LW_MIX:  cmd_zreg_o = {cur_j, cur_i[0]};
            LW_32:   cmd_zreg_o = {cur_j[LIDX_W-2:0], zrow_q[1:0]};
            LW_64:   cmd_zreg_o = {cur_j[LIDX_W-3:0], zrow_q};
            default: cmd_zreg_o = {cur_j, zrow_q[0]};
        endcase
    end

    // Drive the remaining command outputs from the latched state.
    always_comb begin
        cmd_valid_o = valid_q;
        cmd_xlane_o = cur_i;
        cmd_ylane_o = cur_j;
        cmd_alu_o   = alu_q;
        cmd_fz_o    = fz_q;
        done_o      = done_q;
    end

    logic unused_fx0;
    assign unused_fx0 = fx0_ok;

    // R2, R3: a cancelled operation emits nothing and reports done.
    p_noop_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !cmd_valid_o && dec_noop) |=> (!cmd_valid_o && done_o));

    // R10: command fields stay put under back-pressure.
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_zreg_o) &&
            $stable(cmd_xlane_o) && $stable(cmd_ylane_o) &&
            $stable(cmd_alu_o) && $stable(cmd_fz_o)));

    // R9: every emitted command addresses an enabled lane pair.
    p_lane_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (x_vec[cmd_xlane_o] && y_vec[cmd_ylane_o]));

    // R9: the next command after an acceptance is strictly later in j-then-i order.
    p_walk_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ready_i) |=> (!cmd_valid_o ||
            (cmd_ylane_o > $past(cmd_ylane_o)) ||
            ((cmd_ylane_o == $past(cmd_ylane_o)) && (cmd_xlane_o > $past(cmd_xlane_o)))));

    // R11: done lasts one cycle and never overlaps a pending command.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cmd_valid_o);

    // R3: the ALU code never takes the unused encoding.
    p_alu_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_alu_o != 2'd3));

endmodule

// File: tb/opacc_cmd_seq_tb.sv
module opacc_cmd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] op_i = '0;
    logic [63:0] xen_i = '0;
    logic [63:0] yen_i = '0;
    logic        cmd_ready_i = 1'b1;
    logic        cmd_valid_o;
    logic [5:0]  cmd_zreg_o;
    logic [4:0]  cmd_xlane_o;
    logic [4:0]  cmd_ylane_o;
    logic [1:0]  cmd_alu_o;
    logic        cmd_fz_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    opacc_cmd_seq dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .op_i (op_i),
        .xen_i (xen_i), .yen_i (yen_i), .cmd_valid_o (cmd_valid_o),
        .cmd_ready_i (cmd_ready_i), .cmd_zreg_o (cmd_zreg_o),
        .cmd_xlane_o (cmd_xlane_o), .cmd_ylane_o (cmd_ylane_o),
        .cmd_alu_o (cmd_alu_o), .cmd_fz_o (cmd_fz_o), .done_o (done_o)
    );

    typedef struct packed {
        logic [3:0]  lw;
        logic [5:0]  alu;
        logic [2:0]  zr;
        logic [63:0] extra;
        logic [63:0] xen;
        logic [63:0] yen;
        logic [7:0]  cnt;
        logic [1:0]  acode;
        logic        fz;
        logic [5:0]  z0;
        logic [4:0]  x0;
        logic [4:0]  y0;
        logic [5:0]  zl;
        logic [4:0]  xl;
        logic [4:0]  yl;
    } vec_t;

    localparam int NV = 10;
    // V0 16/16 R6; V1 32/32 sub R7; V2 64/64 select R7; V3 mixed R8;
    // V4 bit53 forcing R4; V5 bad mode R3; V6 reserved bits R2;
    // V7 off-boundary mask R5; V8 x zero override R13; V9 y zero override R13.
    localparam vec_t VECS [NV] = '{
        '{4'd0, 6'd0, 3'd1, 64'h0, 64'h5, 64'h50, 8'd4, 2'd0, 1'b0,
          6'd5, 5'd0, 5'd2, 6'd7, 5'd1, 5'd3},
        '{4'd4, 6'd1, 3'd2, 64'h0, 64'h1000_0000_0000_0014, 64'h101, 8'd4, 2'd1, 1'b0,
          6'd2, 5'd1, 5'd0, 6'd10, 5'd15, 5'd2},
        '{4'd7, 6'd4, 3'd5, 64'h0, 64'h0100_0000_0000_0102, 64'h0100_0000_0000_0000,
          8'd2, 2'd2, 1'b0, 6'd61, 5'd1, 5'd7, 6'd61, 5'd7, 5'd7},
        '{4'd3, 6'd0, 3'd3, 64'h0, 64'h5, 64'h4000_0000_0000_0000, 8'd2, 2'd0, 1'b0,
          6'd62, 5'd0, 5'd31, 6'd63, 5'd1, 5'd31},
        '{4'd9, 6'd5, 3'd0, 64'h0020_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h1,
          8'd1, 2'd0, 1'b0, 6'd0, 5'd31, 5'd0, 6'd0, 5'd31, 5'd0},
        '{4'd0, 6'd2, 3'd0, 64'h0, 64'h1, 64'h1, 8'd0, 2'd0, 1'b0,
          6'd0, 5'd0, 5'd0, 6'd0, 5'd0, 5'd0},
        '{4'd0, 6'd0, 3'd0, 64'h0080_0000_0000_0000, 64'h1, 64'h1, 8'd0, 2'd0, 1'b0,
          6'd0, 5'd0, 5'd0, 6'd0, 5'd0, 5'd0},
        '{4'd0, 6'd0, 3'd0, 64'h0, 64'h2, 64'h1, 8'd0, 2'd0, 1'b0,
          6'd0, 5'd0, 5'd0, 6'd0, 5'd0, 5'd0},
        '{4'd0, 6'd0, 3'd0, 64'h0000_0023_0000_0000, 64'h1, 64'h1, 8'd1, 2'd0, 1'b1,
          6'd0, 5'd0, 5'd0, 6'd0, 5'd0, 5'd0},
        '{4'd0, 6'd0, 3'd0, 64'h8C00_0000_0000_0000, 64'h1, 64'h1, 8'd1, 2'd0, 1'b1,
          6'd0, 5'd0, 5'd0, 6'd0, 5'd0, 5'd0}
    };

    function automatic logic [63:0] mkop(vec_t v);
        return (64'(v.lw) << 42) | (64'(v.alu) << 47) | (64'(v.zr) << 20) | v.extra;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Start pulse: drive at a falling edge, release one cycle later.
    task automatic do_start(input logic [63:0] op, input logic [63:0] xm, input logic [63:0] ym);
        @(negedge clk);
        op_i = op; xen_i = xm; yen_i = ym; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int got;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 64'(cmd_valid_o), 0);
        chk("R1 done in reset", 64'(done_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 64'(cmd_valid_o), 0);
        chk("R1 done after reset", 64'(done_o), 0);

        // Table walk, ready held high: R2..R9, R11, R13
        for (int v = 0; v < NV; v++) begin
            vec_t e;
            e = VECS[v];
            cmd_ready_i = 1'b1;
            do_start(mkop(e), e.xen, e.yen);
            got = 0;
            for (int c = 0; c < int'(e.cnt); c++) begin
                chk($sformatf("R9 v%0d valid back-to-back c%0d", v, c), 64'(cmd_valid_o), 1);
                chk($sformatf("R3 R4 v%0d alu code", v), 64'(cmd_alu_o), 64'(e.acode));
                chk($sformatf("R13 v%0d force-zero", v), 64'(cmd_fz_o), 64'(e.fz));
                if (c == 0) begin
                    chk($sformatf("R5 R6 R7 R8 v%0d first zreg", v), 64'(cmd_zreg_o), 64'(e.z0));
                    chk($sformatf("R5 R9 v%0d first xlane", v), 64'(cmd_xlane_o), 64'(e.x0));
                    chk($sformatf("R5 R9 v%0d first ylane", v), 64'(cmd_ylane_o), 64'(e.y0));
                end
                if (c == int'(e.cnt) - 1) begin
                    chk($sformatf("R6 R7 R8 v%0d last zreg", v), 64'(cmd_zreg_o), 64'(e.zl));
                    chk($sformatf("R9 v%0d last xlane", v), 64'(cmd_xlane_o), 64'(e.xl));
                    chk($sformatf("R9 v%0d last ylane", v), 64'(cmd_ylane_o), 64'(e.yl));
                end
                @(negedge clk);
            end
            chk($sformatf("R2 R9 v%0d no extra command", v), 64'(cmd_valid_o), 0);
            chk($sformatf("R11 v%0d done timing", v), 64'(done_o), 1);
            @(negedge clk);
            chk($sformatf("R11 v%0d done one cycle", v), 64'(done_o), 0);
        end

        // R10 and R12: stall with a competing start in the middle
        begin
            vec_t a, b;
            logic [5:0] z_hold;
            logic [4:0] x_hold, y_hold;
            a = VECS[0];
            b = VECS[2];
            cmd_ready_i = 1'b0;
            do_start(mkop(a), a.xen, a.yen);
            z_hold = cmd_zreg_o; x_hold = cmd_xlane_o; y_hold = cmd_ylane_o;
            chk("R10 valid under stall", 64'(cmd_valid_o), 1);
            op_i = mkop(b); xen_i = b.xen; yen_i = b.yen; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            for (int s = 0; s < 3; s++) begin
                chk("R10 zreg held", 64'(cmd_zreg_o), 64'(z_hold));
                chk("R10 xlane held", 64'(cmd_xlane_o), 64'(x_hold));
                chk("R10 ylane held", 64'(cmd_ylane_o), 64'(y_hold));
                chk("R10 R12 alu held", 64'(cmd_alu_o), 64'(a.acode));
                @(negedge clk);
            end
            cmd_ready_i = 1'b1;
            got = 0;
            for (int c = 0; c < 10 && cmd_valid_o; c++) begin
                got++;
                if (got == 4) begin
                    chk("R12 last zreg of first op", 64'(cmd_zreg_o), 64'(a.zl));
                end
                @(negedge clk);
            end
            chk("R12 command count kept", 64'(got), 64'(a.cnt));
            chk("R11 done after stalled run", 64'(done_o), 1);
            @(negedge clk);
            chk("R12 no second run", 64'(cmd_valid_o), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule